// File: doc/BRIEF.md
# Memory-Mapped Core Interval Timer

This block is a 32-bit down-counting interval timer placed on a simple word-wide register bus. Software programs a reload value, a prescale divisor and a few control bits. While both the power bit and the run bit are set, the counter drops by one each time an 8-bit prescaler wraps. When the counter moves from 1 to 0, the block sets a sticky status bit and raises a one-cycle interrupt pulse. It then either reloads from the period register and keeps going, or stays at zero.

Software reaches four registers through single-cycle reads and writes. Read data and the error flag are registered and appear in the cycle after the request. Only aligned accesses with all byte lanes enabled are accepted. Any other access raises the error flag and changes nothing. The status bit is an ordinary read/write bit: a control write stores exactly the value written, so software clears the status by writing 0 to that bit.

Top module: `core_itimer`

## Requirements
- R1: The registers sit at byte offsets 0x0 (control), 0x4 (period), 0x8 (scale) and 0xC (count). All of them reset to 0. A valid read returns the register on bus_rdata in the cycle after the request, with the value the register held before that request's clock edge. Control bits above bit 3 always read 0, and scale reads back all 32 written bits.
- R2: Control bit 0 is power and bit 1 is run. The counter and the prescaler advance only while both bits are 1. Otherwise count holds its value and the prescaler is held at phase 0.
- R3: While running, count drops by 1 every scale[7:0]+1 clocks. The first decrement lands on the (scale[7:0]+1)-th clock edge after the edge that started the timer.
- R4: On the edge where count goes from 1 to 0, control bit 3 (status) is set, and irq_o is 1 for exactly the following cycle.
- R5: If control bit 2 (auto-reload) is 1 at expiry, count is reloaded from period and counting continues. Otherwise count stays at 0 and no further interrupt occurs until a nonzero count is written.
- R6: A write to period also writes the same value into count.
- R7: A write to control stores bits [3:0] as written, so status is cleared by writing 0 and set by writing 1, and no interrupt is raised. An expiry in the same cycle as a control write still sets status.
- R8: Count and period can be written while the timer runs. Such a write takes priority over a prescaler tick in the same cycle, and that tick is dropped.
- R9: An access with bus_be other than all ones, or with bus_addr[1:0] nonzero, sets bus_err for the following cycle, returns 0 on bus_rdata and changes no register.
- R10: A write to scale restarts the prescaler at phase 0 and leaves count unchanged, so the next decrement comes new scale[7:0]+1 clocks after the write.
- R11: A read of count while running returns the value decremented so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte address within the block |
| bus_be | input | DATA_W/8 | Byte lane enables; all must be set |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Registered rejected-access flag |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The assertions assume that bus inputs are stable across each rising edge and that reset is held for at least one edge before any access. They also assume that a period or count write is the only thing, besides a tick, that can move the counter while it is stopped. The bench changes every input at the falling edge and releases reset only after several cycles. Its random traffic keeps period and count below 8 and scale[7:0] below 4, so that expiries, reloads and same-cycle collisions between writes and ticks occur often. Narrow and misaligned accesses are mixed into that traffic.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int REG_ADDR_W = 4;
  localparam int CTRL_W     = 4;
  localparam int CB_PWR     = 0;
  localparam int CB_EN      = 1;
  localparam int CB_ARL     = 2;
  localparam int CB_STAT    = 3;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SCALE  = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;

  assign tick_o = run_i && (phase_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i || !run_i) phase_q <= '0;
    else if (tick_o)                phase_q <= '0;
    else                            phase_q <= phase_q + PRE_W'(1);
  end

  // R3: phase never runs past the divisor
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase_q <= div_i);
  // R2: a stopped timer keeps the prescaler at phase 0
  a_r2_phase_held: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> phase_q == '0);
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         reload_en_i,
  input  logic [W-1:0] period_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && !ld_i && (cnt_q == W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (ld_i)                    cnt_q <= ld_val_i;
    else if (expire_o)                cnt_q <= reload_en_i ? period_i : '0;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  // R5: auto-reload takes the period value
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (expire_o && reload_en_i) |=> cnt_q == $past(period_i));
  // R5: without reload the counter rests at zero
  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !reload_en_i) |=> cnt_q == '0);
  // R8: a load beats a tick
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/core_itimer.sv
module core_itimer
  import itmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_err,
  output logic                  irq_o
);
  localparam int BE_W = DATA_W / 8;

  logic              acc_ok, acc_bad;
  logic              wr_ctrl, wr_per, wr_scl, wr_cnt, rd_ok;
  reg_sel_e          rsel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] period_q, scale_q, cnt;
  logic              run, tick, expire;
  logic [DATA_W-1:0] rd_mux;

  assign rsel    = reg_sel_e'(bus_addr[3:2]);
  assign acc_ok  = bus_sel && (bus_be == {BE_W{1'b1}}) && (bus_addr[1:0] == 2'b00);
  assign acc_bad = bus_sel && !acc_ok;
  assign wr_ctrl = acc_ok && bus_we && (rsel == SEL_CTRL);
  assign wr_per  = acc_ok && bus_we && (rsel == SEL_PERIOD);
  assign wr_scl  = acc_ok && bus_we && (rsel == SEL_SCALE);
  assign wr_cnt  = acc_ok && bus_we && (rsel == SEL_COUNT);
  assign rd_ok   = acc_ok && !bus_we;
  assign run     = ctrl_q[CB_PWR] && ctrl_q[CB_EN];

  itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run),
    .restart_i (wr_scl),
    .div_i     (scale_q[PRE_W-1:0]),
    .tick_o    (tick)
  );

  itmr_counter #(.W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .reload_en_i (ctrl_q[CB_ARL]),
    .period_i    (period_q),
    .ld_i        (wr_per || wr_cnt),
    .ld_val_i    (bus_wdata),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q          <= bus_wdata[CTRL_W-1:0];
        ctrl_q[CB_STAT] <= bus_wdata[CB_STAT] || expire;
      end else if (expire) begin
        ctrl_q[CB_STAT] <= 1'b1;
      end
      if (wr_per) period_q <= bus_wdata;
      if (wr_scl) scale_q  <= bus_wdata;
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      SEL_PERIOD: rd_mux = period_q;
      SEL_SCALE:  rd_mux = scale_q;
      SEL_COUNT:  rd_mux = cnt;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_ok ? rd_mux : '0;
      bus_err   <= acc_bad;
      irq_o     <= expire;
    end
  end

  // R4: every interrupt pulse is accompanied by a set status bit
  a_r4_irq_status: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ctrl_q[CB_STAT]);
  // R6: period writes land in count too
  a_r6_mirror: assert property (@(posedge clk) disable iff (rst)
    wr_per |=> cnt == $past(bus_wdata));
  // R2: a stopped timer without count or period writes keeps count
  a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_per && !wr_cnt) |=> $stable(cnt));
  // R9: rejected accesses leave period and scale alone
  a_r9_no_effect: assert property (@(posedge clk) disable iff (rst)
    acc_bad |=> ($stable(period_q) && $stable(scale_q)));
endmodule

// File: tb/core_itimer_tb_top.sv
`timescale 1ns/1ps
module core_itimer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_itimer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements, stepped at each rising edge.
  logic [31:0] m_ctrl, m_per, m_scl, m_cnt, m_nc, m_rd;
  int          m_pc;
  logic        m_irq, m_err, m_rdv, m_run, m_tk, m_good, m_exp;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_per = 0; m_scl = 0; m_cnt = 0; m_pc = 0;
      m_irq = 0; m_err = 0; m_rd = 0; m_rdv = 0;
    end else begin
      m_run  = m_ctrl[0] && m_ctrl[1];
      m_tk   = m_run && (m_pc == int'(m_scl[7:0]));
      m_good = bus_sel && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
      m_err  = bus_sel && !m_good;
      m_rdv  = bus_sel;
      m_rd   = 0;
      if (m_good && !bus_we)
        case (bus_addr[3:2])
          2'd0: m_rd = m_ctrl;
          2'd1: m_rd = m_per;
          2'd2: m_rd = m_scl;
          default: m_rd = m_cnt;
        endcase
      m_exp = 0;
      m_nc  = m_cnt;
      if (m_tk && m_cnt != 0) begin
        if (m_cnt == 1) begin m_exp = 1; m_nc = m_ctrl[2] ? m_per : 0; end
        else m_nc = m_cnt - 1;
      end
      m_pc = (!m_run || m_tk) ? 0 : m_pc + 1;
      if (m_good && bus_we)
        case (bus_addr[3:2])
          2'd0: m_ctrl = {28'd0, bus_wdata[3:0]};
          2'd1: begin m_per = bus_wdata; m_nc = bus_wdata; m_exp = 0; end
          2'd2: begin m_scl = bus_wdata; m_pc = 0; end
          default: begin m_nc = bus_wdata; m_exp = 0; end
        endcase
      if (m_exp) m_ctrl[3] = 1'b1;
      m_cnt = m_nc;
      m_irq = m_exp;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_o) irq_cnt++;
      if (irq_o !== m_irq) chk("R4 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
      if (m_rdv) begin
        chk("R9 err vs model", {31'd0, bus_err}, {31'd0, m_err});
        chk("R1 rdata vs model", bus_rdata, m_rd);
      end
    end
  end

  task automatic bus_op(input logic [3:0] a, input logic w, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] rv, output logic ev);
    bus_sel = 1; bus_we = w; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    rv = bus_rdata; ev = bus_err;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rv; logic ev;
    bus_op(a, 1'b1, 4'hF, d, rv, ev);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    logic ev;
    bus_op(a, 1'b0, 4'hF, 32'd0, v, ev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; logic e; int first_k, snap;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset values
    rd(4'h0, v); chk("R1 ctrl reset", v, 0);
    rd(4'h4, v); chk("R1 period reset", v, 0);
    rd(4'h8, v); chk("R1 scale reset", v, 0);
    rd(4'hC, v); chk("R1 count reset", v, 0);
    // R6
    wr(4'h4, 32'd5);
    rd(4'hC, v); chk("R6 count mirrors period", v, 5);
    rd(4'h4, v); chk("R6 period value", v, 5);
    // R1 unused control bits
    wr(4'h0, 32'hFFFF_FFF0);
    rd(4'h0, v); chk("R1 unused ctrl bits", v, 0);
    wr(4'h8, 32'hABCD_1200);
    rd(4'h8, v); chk("R1 scale full width", v, 32'hABCD_1200);
    // R2: only one of the two bits set
    wr(4'h0, 32'd1); repeat (20) @(negedge clk);
    rd(4'hC, v); chk("R2 power only frozen", v, 5);
    wr(4'h0, 32'd2); repeat (20) @(negedge clk);
    rd(4'hC, v); chk("R2 run only frozen", v, 5);
    // R3/R4: scale 2, count 4, expiry 12 edges after start
    wr(4'h8, 32'd2); wr(4'h4, 32'd4); wr(4'h0, 32'd3);
    first_k = -1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (irq_o && first_k < 0) first_k = k;
    end
    chk("R3 expiry timing", first_k, 12);
    rd(4'h0, v); chk("R4 status set", v, 32'hB);
    rd(4'hC, v); chk("R5 stays zero", v, 0);
    #1 snap = irq_cnt;
    repeat (30) @(negedge clk);
    #1 chk("R5 no further irq", irq_cnt - snap, 0);
    // R7
    wr(4'h0, 32'd3); rd(4'h0, v); chk("R7 status cleared", v, 3);
    #1 snap = irq_cnt;
    wr(4'h0, 32'd8); rd(4'h0, v); chk("R7 status written", v, 8);
    #1 chk("R7 no irq on write", irq_cnt - snap, 0);
    // R5 auto-reload: scale 0, period 3
    wr(4'h8, 32'd0); wr(4'h4, 32'd3); wr(4'h0, 32'd7);
    #1 snap = irq_cnt;
    repeat (30) @(negedge clk);
    #1 chk("R5 reload irq count", irq_cnt - snap, 10);
    wr(4'h0, 32'd0);
    // R11: scale 9, period 100
    wr(4'h8, 32'd9); wr(4'h4, 32'd100); wr(4'h0, 32'd3);
    repeat (35) @(negedge clk);
    rd(4'hC, v); chk("R11 running count", v, 97);
    // R10: scale rewrite restarts phase
    wr(4'h8, 32'd9);
    repeat (9) @(negedge clk);
    rd(4'hC, v); chk("R10 count kept", v, 97);
    rd(4'hC, v); chk("R10 next tick", v, 96);
    // R8
    wr(4'hC, 32'd7); rd(4'hC, v); chk("R8 count write running", v, 7);
    wr(4'h4, 32'd50); rd(4'hC, v); chk("R8 period write running", v, 50);
    wr(4'h8, 32'd0); wr(4'hC, 32'd20);
    rd(4'hC, v); chk("R8 write beats tick", v, 20);
    rd(4'hC, v); chk("R3 scale0 decrement", v, 19);
    wr(4'h0, 32'd0);
    // R9
    bus_op(4'h4, 1'b1, 4'b0011, 32'd9, v, e); chk("R9 narrow write err", e, 1);
    rd(4'h4, v); chk("R9 period unchanged", v, 50);
    bus_op(4'h5, 1'b1, 4'hF, 32'd9, v, e); chk("R9 misaligned err", e, 1);
    rd(4'h4, v); chk("R9 period still", v, 50);
    bus_op(4'h4, 1'b0, 4'b1000, 32'd0, v, e);
    chk("R9 narrow read err", e, 1); chk("R9 narrow read data", v, 0);
    // Random traffic checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a, b; logic w; logic [31:0] d;
      a = 4'((($urandom % 4)) << 2);
      w = ($urandom % 3) != 0;
      b = 4'hF;
      if (($urandom % 12) == 0) begin
        if ($urandom % 2) b = 4'($urandom % 15); else a = a | 4'(1 + $urandom % 3);
      end
      case (a[3:2])
        2'd0: d = ($urandom % 5 != 0) ? ($urandom | 32'd3) : $urandom;
        2'd2: d = ($urandom & 32'hFFFF_FF00) | ($urandom % 4);
        default: d = $urandom % 8;
      endcase
      bus_op(a, w, b, d, v, e);
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule